// File: doc/BRIEF.md
# Double-Buffered Packet Commit Controller

This block sits between a packet receiver and a downstream FIFO. Received packets land in one of two ping-pong buffers. In manual mode each held packet waits for a decision from a local processor, which reaches the block through a small byte-wide register port and a direct buffer write port. The processor can pass the packet on untouched, drop it, or overwrite any of its bytes and give it a new length before releasing it. In automatic mode a packet is released as soon as its last byte arrives.

After reset no buffer may receive. The processor first issues the packet-end command with the skip flag set, once for each buffer, to arm both. A buffer whose packet has been dropped re-arms at once. A buffer whose packet has been released re-arms after the downstream side has read its final byte. A FIFO-reset command returns everything to the post-reset state. The downstream side sees a valid/ready byte stream with a marker on the last byte of each packet.

Top module: `pkt_commit_ctrl`

## Requirements
- R1: After reset no buffer is armed (`buf_armed` = 2'b00), `rx_full` is high and `out_valid` is low.
- R2: A register write to address 0 (packet-end command, skip flag in bit 7) made while no packet awaits a decision arms the next unarmed buffer. Two such writes after reset arm both buffers (`buf_armed` = 2'b11).
- R3: A receiver byte is taken only while `rx_full` is low. `rx_full` is high whenever the buffer due to receive next is not armed, including when both buffers hold undecided packets.
- R4: With `auto_mode` low, a fully received packet produces no downstream output until the processor acts on it.
- R5: A packet-end write with bit 7 clear releases the oldest undecided packet unchanged. Its bytes appear in order, one per accepted beat, starting in the cycle after the write, and `out_last` marks the final byte.
- R6: A packet-end write with bit 7 set drops the oldest undecided packet. None of its bytes ever appear downstream.
- R7: The processor may write bytes into the buffer under decision (or, when none is held, into the next unarmed buffer) and then write the length high byte to address 1 and the low byte to address 2. The low-byte write releases that buffer with length {high, low}. A high-byte write alone changes nothing.
- R8: A length above 512 written through R7 is reduced to 512.
- R9: A buffer freed by a drop is armed in the cycle after the command. A released buffer is armed in the cycle after its last byte is accepted downstream.
- R10: With `auto_mode` high, each received packet is released without any processor action.
- R11: Any register write to address 3 empties both buffers, clears all lengths and undecided packets, and leaves no buffer armed.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R13: Packets leave the block in the order in which they were released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_mode | input | 1 | 1: release packets on arrival; 0: hold for processor |
| rx_valid | input | 1 | Receiver byte present |
| rx_data | input | DW | Receiver byte |
| rx_last | input | 1 | Receiver byte is the final byte of its packet |
| rx_full | output | 1 | Receiver is refused this cycle |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register select: 0 packet-end, 1 length high, 2 length low, 3 FIFO reset |
| cpu_wdata | input | 8 | Register write byte |
| cpu_buf_we | input | 1 | Buffer byte write strobe |
| cpu_buf_addr | input | log2(BUF_BYTES) | Byte offset within the buffer under decision |
| cpu_buf_wdata | input | DW | Buffer byte to write |
| out_valid | output | 1 | Downstream byte present |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | DW | Downstream byte |
| out_last | output | 1 | Downstream byte ends its packet |
| buf_armed | output | 2 | Per-buffer flag: armed and free to receive |

## Verification
Every register command and every completed receive changes buffer state at the next rising edge. `buf_armed`, `rx_full` and the first byte of a released packet are therefore due one cycle after the stimulus. Later bytes follow one per cycle while `out_ready` is high, and re-arming after a release is due one cycle after the final beat. The bench drives inputs on falling edges and samples outputs on the falling edge that follows the edge which should act. An expected-byte queue is filled before each release command or automatic-mode send, so a monitor comparing on every downstream handshake always finds its reference ready. Any beat arriving with an empty queue is reported as a leak from a dropped or withheld packet.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    localparam int PCC_BUF_BYTES = 512;
    localparam int PCC_DW        = 8;
    localparam int PCC_NBUF      = 2;
    localparam int PCC_SKIP_BIT  = 7;

    localparam logic [1:0] REG_PKTEND   = 2'd0;
    localparam logic [1:0] REG_LEN_HI   = 2'd1;
    localparam logic [1:0] REG_LEN_LO   = 2'd2;
    localparam logic [1:0] REG_FIFO_RST = 2'd3;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_ARMED,
        BS_HELD,
        BS_READY
    } buf_state_e;

    typedef struct packed {
        logic        pktend;
        logic        skip;
        logic        len_commit;
        logic [15:0] len_raw;
        logic        fifo_rst;
    } cpu_cmd_t;

    typedef struct packed {
        logic clear;
        logic rx_done;
        logic cpu_commit;
        logic cpu_skip;
        logic cpu_arm;
        logic cpu_edit;
        logic drain_done;
    } slot_evt_t;

    function automatic logic [15:0] clamp_len(input logic [15:0] raw,
                                              input int unsigned limit);
        if (32'(raw) > limit) return 16'(limit);
        return raw;
    endfunction

endpackage

// File: rtl/pcc_cpu_regs.sv
module pcc_cpu_regs
    import pcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_we,
    input  logic [1:0] cpu_addr,
    input  logic [7:0] cpu_wdata,
    output cpu_cmd_t   cmd
);
    logic [7:0] len_hi_q;

    always_comb begin
        cmd.pktend     = cpu_we && (cpu_addr == REG_PKTEND);
        cmd.skip       = cpu_wdata[PCC_SKIP_BIT];
        cmd.len_commit = cpu_we && (cpu_addr == REG_LEN_LO);
        cmd.len_raw    = {len_hi_q, cpu_wdata};
        cmd.fifo_rst   = cpu_we && (cpu_addr == REG_FIFO_RST);
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.fifo_rst) begin
            len_hi_q <= '0;
        end else if (cpu_we && (cpu_addr == REG_LEN_HI)) begin
            len_hi_q <= cpu_wdata;
        end
    end
endmodule

// File: rtl/pcc_slot.sv
module pcc_slot
    import pcc_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  slot_evt_t     evt,
    input  logic          auto_mode,
    input  logic [CW-1:0] rx_len,
    input  logic [CW-1:0] edit_len,
    output buf_state_e    state,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || evt.clear) begin
            state <= BS_IDLE;
            count <= '0;
        end else begin
            if (evt.rx_done) begin
                state <= auto_mode ? BS_READY : BS_HELD;
                count <= rx_len;
            end
            if (evt.cpu_commit) begin
                state <= BS_READY;
            end
            if (evt.cpu_skip || evt.cpu_arm) begin
                state <= BS_ARMED;
                count <= '0;
            end
            if (evt.cpu_edit) begin
                state <= BS_READY;
                count <= edit_len;
            end
            if (evt.drain_done) begin
                state <= BS_ARMED;
                count <= '0;
            end
        end
    end
endmodule

// File: rtl/pcc_buf_ram.sv
module pcc_buf_ram #(
    parameter int NBUF      = 2,
    parameter int BUF_BYTES = 512,
    parameter int DW        = 8,
    localparam int AW       = $clog2(BUF_BYTES),
    localparam int BW       = $clog2(NBUF)
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic [BW-1:0] a_buf,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_data,
    input  logic          b_en,
    input  logic [BW-1:0] b_buf,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_data,
    input  logic [BW-1:0] r_buf,
    input  logic [AW-1:0] r_addr,
    output logic [DW-1:0] r_data
);
    logic [DW-1:0] mem [NBUF][BUF_BYTES];
    logic          b_clash;

    assign b_clash = a_en && (a_buf == b_buf) && (a_addr == b_addr);
    assign r_data  = mem[r_buf][r_addr];

    always_ff @(posedge clk) begin
        if (a_en) begin
            mem[a_buf][a_addr] <= a_data;
        end
        if (b_en && !b_clash) begin
            mem[b_buf][b_addr] <= b_data;
        end
    end
endmodule

// File: rtl/pcc_drain.sv
module pcc_drain #(
    parameter int BUF_BYTES = 512,
    localparam int AW       = $clog2(BUF_BYTES),
    localparam int CW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          active,
    input  logic [CW-1:0] count,
    input  logic          ready,
    output logic [AW-1:0] rd_addr,
    output logic          valid,
    output logic          last,
    output logic          done
);
    logic [AW-1:0] rpos;

    assign rd_addr = rpos;
    assign valid   = active && (count != '0);
    assign last    = valid && ({1'b0, rpos} == (count - 1'b1));
    assign done    = active && ((count == '0) || (ready && last));

    always_ff @(posedge clk) begin
        if (rst || clr || done) begin
            rpos <= '0;
        end else if (valid && ready) begin
            rpos <= rpos + 1'b1;
        end
    end
endmodule

// File: rtl/pkt_commit_ctrl.sv
module pkt_commit_ctrl
    import pcc_pkg::*;
#(
    parameter int BUF_BYTES = PCC_BUF_BYTES,
    parameter int DW        = PCC_DW,
    localparam int AW       = $clog2(BUF_BYTES),
    localparam int CW       = AW + 1,
    localparam int NBUF     = PCC_NBUF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          auto_mode,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_last,
    output logic          rx_full,
    input  logic          cpu_we,
    input  logic [1:0]    cpu_addr,
    input  logic [7:0]    cpu_wdata,
    input  logic          cpu_buf_we,
    input  logic [AW-1:0] cpu_buf_addr,
    input  logic [DW-1:0] cpu_buf_wdata,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          out_last,
    output logic [1:0]    buf_armed
);
    localparam logic [CW-1:0] MAX_CNT = CW'(BUF_BYTES);

    cpu_cmd_t      cmd;
    buf_state_e    st  [NBUF];
    logic [CW-1:0] cnt [NBUF];

    logic          rx_ptr, rx_sel, cpu_ptr, cpu_sel, out_ptr, out_sel;
    logic [CW-1:0] wpos, rx_len, edit_len;
    logic          rx_acc, rx_wr, rx_done, rx_busy;
    logic          act_commit, act_skip, act_arm, act_edit, cpu_adv;
    logic          drain_active, drain_done;
    logic [AW-1:0] rd_addr;
    buf_state_e    sel_st;

    pcc_cpu_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cmd      (cmd)
    );

    // Receive side: stay on the current buffer mid-packet, otherwise take
    // whichever buffer is armed, preferring the one in ping-pong turn.
    assign rx_busy = (wpos != '0);
    assign rx_sel  = (rx_busy || st[rx_ptr] == BS_ARMED) ? rx_ptr : ~rx_ptr;
    assign rx_full = (st[rx_sel] != BS_ARMED);
    assign rx_acc  = rx_valid && !rx_full;
    assign rx_wr   = rx_acc && (wpos < MAX_CNT);
    assign rx_done = rx_acc && rx_last;
    assign rx_len  = (wpos >= MAX_CNT) ? MAX_CNT : (wpos + 1'b1);

    always_ff @(posedge clk) begin
        if (rst || cmd.fifo_rst) begin
            wpos   <= '0;
            rx_ptr <= 1'b0;
        end else if (rx_done) begin
            wpos   <= '0;
            rx_ptr <= ~rx_sel;
        end else if (rx_acc) begin
            if (wpos < MAX_CNT) wpos <= wpos + 1'b1;
            rx_ptr <= rx_sel;
        end
    end

    // Processor side: oldest held packet first, else an unarmed buffer.
    always_comb begin
        if (st[cpu_ptr] == BS_HELD)       cpu_sel = cpu_ptr;
        else if (st[~cpu_ptr] == BS_HELD) cpu_sel = ~cpu_ptr;
        else if (st[cpu_ptr] == BS_IDLE)  cpu_sel = cpu_ptr;
        else                              cpu_sel = ~cpu_ptr;
    end

    assign sel_st     = st[cpu_sel];
    assign act_commit = cmd.pktend && !cmd.skip && (sel_st == BS_HELD);
    assign act_skip   = cmd.pktend &&  cmd.skip && (sel_st == BS_HELD);
    assign act_arm    = cmd.pktend && (sel_st == BS_IDLE);
    assign act_edit   = cmd.len_commit && (sel_st == BS_HELD || sel_st == BS_IDLE);
    assign cpu_adv    = act_commit || act_skip || act_arm || act_edit;
    assign edit_len   = CW'(clamp_len(cmd.len_raw, BUF_BYTES));

    always_ff @(posedge clk) begin
        if (rst || cmd.fifo_rst) begin
            cpu_ptr <= 1'b0;
        end else if (cpu_adv) begin
            cpu_ptr <= ~cpu_sel;
        end
    end

    // Downstream side: drain whichever buffer was released first.
    assign out_sel      = (st[out_ptr] == BS_READY) ? out_ptr : ~out_ptr;
    assign drain_active = (st[out_sel] == BS_READY);

    always_ff @(posedge clk) begin
        if (rst || cmd.fifo_rst) begin
            out_ptr <= 1'b0;
        end else if (drain_done) begin
            out_ptr <= ~out_sel;
        end else if (drain_active) begin
            out_ptr <= out_sel;
        end
    end

    pcc_drain #(.BUF_BYTES(BUF_BYTES)) u_drain (
        .clk    (clk),
        .rst    (rst),
        .clr    (cmd.fifo_rst),
        .active (drain_active),
        .count  (cnt[out_sel]),
        .ready  (out_ready),
        .rd_addr(rd_addr),
        .valid  (out_valid),
        .last   (out_last),
        .done   (drain_done)
    );

    pcc_buf_ram #(.NBUF(NBUF), .BUF_BYTES(BUF_BYTES), .DW(DW)) u_ram (
        .clk   (clk),
        .a_en  (rx_wr),
        .a_buf (rx_sel),
        .a_addr(wpos[AW-1:0]),
        .a_data(rx_data),
        .b_en  (cpu_buf_we && (sel_st != BS_READY)),
        .b_buf (cpu_sel),
        .b_addr(cpu_buf_addr),
        .b_data(cpu_buf_wdata),
        .r_buf (out_sel),
        .r_addr(rd_addr),
        .r_data(out_data)
    );

    for (genvar b = 0; b < NBUF; b++) begin : g_slot
        slot_evt_t ev;
        always_comb begin
            ev.clear      = cmd.fifo_rst;
            ev.rx_done    = rx_done    && (rx_sel  == 1'(b));
            ev.cpu_commit = act_commit && (cpu_sel == 1'(b));
            ev.cpu_skip   = act_skip   && (cpu_sel == 1'(b));
            ev.cpu_arm    = act_arm    && (cpu_sel == 1'(b));
            ev.cpu_edit   = act_edit   && (cpu_sel == 1'(b));
            ev.drain_done = drain_done && (out_sel == 1'(b));
        end

        pcc_slot #(.CW(CW)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .evt      (ev),
            .auto_mode(auto_mode),
            .rx_len   (rx_len),
            .edit_len (edit_len),
            .state    (st[b]),
            .count    (cnt[b])
        );

        assign buf_armed[b] = (st[b] == BS_ARMED);
    end
endmodule

// File: rtl/pcc_commit_chk.sv
module pcc_commit_chk
    import pcc_pkg::*;
#(
    parameter int DW = PCC_DW
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_we,
    input logic [1:0]    cpu_addr,
    input logic          rx_valid,
    input logic          rx_full,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          out_last,
    input logic [1:0]    buf_armed
);
    logic fifo_rst_wr;
    assign fifo_rst_wr = cpu_we && (cpu_addr == REG_FIFO_RST);

    AST_FIFO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        fifo_rst_wr |=> (buf_armed == 2'b00 && !out_valid && rx_full)); // R11

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid); // R5

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !fifo_rst_wr)
        |=> (out_valid && $stable(out_data) && $stable(out_last))); // R12

    AST_FULL_WHEN_UNARMED: assert property (@(posedge clk) disable iff (rst)
        (buf_armed == 2'b00) |-> rx_full); // R3

    AST_HI_BYTE_INERT: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == REG_LEN_HI && !out_valid && !(rx_valid && !rx_full))
        |=> !out_valid); // R7
endmodule

bind pkt_commit_ctrl pcc_commit_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_pkt_commit_ctrl.sv
module tb_pkt_commit_ctrl;
    localparam int BB = 512;
    localparam int DW = 8;
    localparam int AW = $clog2(BB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          auto_mode = 1'b0;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          rx_last = 1'b0;
    logic          rx_full;
    logic          cpu_we = 1'b0;
    logic [1:0]    cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic          cpu_buf_we = 1'b0;
    logic [AW-1:0] cpu_buf_addr = '0;
    logic [DW-1:0] cpu_buf_wdata = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_data;
    logic          out_last;
    logic [1:0]    buf_armed;

    pkt_commit_ctrl #(.BUF_BYTES(BB), .DW(DW)) dut (.*);

    // 8-unit period: 125 MHz with 1 ns units
    always #4 clk = ~clk;

    int       n_chk = 0;
    int       n_bad = 0;
    bit       finished = 1'b0;
    bit [7:0] exp_d[$];
    bit       exp_l[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Scoreboard monitor: compares each downstream handshake.
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_d.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R6 unexpected beat: actual %0d expected none", out_data);
            end else begin
                bit [7:0] ed;
                bit       el;
                ed = exp_d.pop_front();
                el = exp_l.pop_front();
                chk(out_data == ed, "R13", "byte order", out_data, ed);
                chk(out_last == el, "R5", "last marker", out_last, el);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic buf_wr(input int a, input logic [7:0] d);
        cpu_buf_we = 1'b1; cpu_buf_addr = AW'(a); cpu_buf_wdata = d;
        @(negedge clk);
        cpu_buf_we = 1'b0;
    endtask

    task automatic send_pkt(input int len, input int seed);
        chk(!rx_full, "R3", "receiver open before send", rx_full, 0);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1; rx_data = 8'(seed + i); rx_last = (i == len - 1);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic push_exp(input bit [7:0] d, input bit l);
        exp_d.push_back(d);
        exp_l.push_back(l);
    endtask

    task automatic expect_pkt(input int len, input int seed);
        for (int i = 0; i < len; i++) push_exp(8'(seed + i), i == len - 1);
    endtask

    task automatic set_ready(input bit v);
        @(posedge clk);
        #1 out_ready = v;
        @(negedge clk);
    endtask

    task automatic wait_drain(input string req);
        int guard = 0;
        while (exp_d.size() != 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(exp_d.size() == 0, req, "all expected bytes delivered", exp_d.size(), 0);
        idle(2);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        bit [7:0] d0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1: post-reset state
        chk(buf_armed == 2'b00, "R1", "buf_armed after reset", buf_armed, 0);
        chk(rx_full == 1'b1, "R1", "rx_full after reset", rx_full, 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // R2: priming with skip commands
        reg_wr(2'd0, 8'h80);
        chk(buf_armed == 2'b01, "R2", "one buffer armed", buf_armed, 1);
        reg_wr(2'd0, 8'h80);
        chk(buf_armed == 2'b11, "R2", "both buffers armed", buf_armed, 3);
        chk(rx_full == 1'b0, "R3", "receiver open once armed", rx_full, 0);

        // R4: manual mode holds packets
        send_pkt(10, 8'h10);
        idle(5);
        chk(out_valid == 1'b0, "R4", "held packet not forwarded", out_valid, 0);
        send_pkt(20, 8'h30);
        idle(1);
        chk(rx_full == 1'b1, "R3", "full with two held packets", rx_full, 1);
        chk(buf_armed == 2'b00, "R3", "no buffer armed when both held", buf_armed, 0);

        // R5: commit oldest unchanged; R9: re-arm after drain
        expect_pkt(10, 8'h10);
        reg_wr(2'd0, 8'h00);
        wait_drain("R5");
        chk(buf_armed == 2'b01, "R9", "released buffer re-armed", buf_armed, 1);
        chk(rx_full == 1'b0, "R9", "receiver open after re-arm", rx_full, 0);

        // R6: skip drops the second packet, R9 re-arms at once
        reg_wr(2'd0, 8'h80);
        chk(buf_armed == 2'b11, "R9", "dropped buffer re-armed next cycle", buf_armed, 3);
        idle(10);
        chk(out_valid == 1'b0, "R6", "dropped packet never output", out_valid, 0);

        // R12, R13: two releases under stall, then drain in order
        send_pkt(5, 8'h50);
        send_pkt(7, 8'h70);
        set_ready(1'b0);
        expect_pkt(5, 8'h50);
        expect_pkt(7, 8'h70);
        reg_wr(2'd0, 8'h00);
        chk(out_valid == 1'b1, "R5", "first byte due one cycle after commit", out_valid, 1);
        d0 = out_data;
        chk(d0 == 8'h50, "R5", "first byte value", d0, 8'h50);
        reg_wr(2'd0, 8'h00);
        idle(2);
        chk(out_valid == 1'b1 && out_data == d0, "R12", "byte held while stalled", out_data, d0);
        set_ready(1'b1);
        wait_drain("R13");

        // R7: edit held packet, high byte alone inert
        send_pkt(16, 8'h40);
        for (int i = 0; i < 4; i++) buf_wr(i, 8'(8'hA0 + i));
        reg_wr(2'd1, 8'h00);
        idle(4);
        chk(out_valid == 1'b0, "R7", "length high byte alone inert", out_valid, 0);
        for (int i = 0; i < 4; i++) push_exp(8'(8'hA0 + i), 1'b0);
        for (int i = 4; i < 8; i++) push_exp(8'(8'h40 + i), i == 7);
        reg_wr(2'd2, 8'h08);
        wait_drain("R7");

        // R8: whole-buffer overwrite with oversize length clamps to 512
        send_pkt(30, 8'h60);
        for (int i = 0; i < BB; i++) buf_wr(i, 8'(i * 7 + 3));
        for (int i = 0; i < BB; i++) push_exp(8'(i * 7 + 3), i == BB - 1);
        reg_wr(2'd1, 8'h03);
        reg_wr(2'd2, 8'h00);
        wait_drain("R8");

        // R11: FIFO reset clears pending packet and arming
        send_pkt(9, 8'h90);
        reg_wr(2'd3, 8'h00);
        chk(buf_armed == 2'b00, "R11", "no buffer armed after FIFO reset", buf_armed, 0);
        chk(rx_full == 1'b1, "R11", "receiver refused after FIFO reset", rx_full, 1);
        idle(5);
        chk(out_valid == 1'b0, "R11", "pending packet lost", out_valid, 0);

        // R7: processor sources a whole packet into an unarmed buffer
        for (int i = 0; i < 6; i++) buf_wr(i, 8'(8'hC0 + i));
        expect_pkt(6, 8'hC0);
        reg_wr(2'd1, 8'h00);
        reg_wr(2'd2, 8'h06);
        wait_drain("R7");
        chk(buf_armed == 2'b01, "R9", "sourced buffer re-armed", buf_armed, 1);

        // R10: automatic mode forwards without processor action
        reg_wr(2'd0, 8'h80);
        chk(buf_armed == 2'b11, "R2", "second buffer armed", buf_armed, 3);
        auto_mode = 1'b1;
        expect_pkt(12, 8'h20);
        send_pkt(12, 8'h20);
        expect_pkt(3, 8'hE0);
        send_pkt(3, 8'hE0);
        wait_drain("R10");

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule